// File: doc/BRIEF.md
# Pipelined FIR Filter with Selectable Structure

This block is a fixed-coefficient finite impulse response filter built for a short register-to-register path. Each cycle it may take one signed sample, marked by a valid strobe, and it returns one full-precision filtered sample with a matching valid strobe after a fixed number of cycles. Tap weights are elaboration-time parameters. Tap 0 weights the newest sample, tap 1 the sample before it, and so on. The sum is never rounded, clipped or wrapped.

A parameter picks one of two structures. The direct structure keeps a line of past samples and adds the tap products in a balanced adder tree, with a register rank after every tree level. Those ranks sit on feed-forward cutsets. The transposed structure sends each new sample to every multiplier at once and passes the partial sums along a chain of registers. In both structures, a second parameter can split each multiplier into two register-separated halves. This shortens the longest path to about one partial multiply and one add. With the same parameters, both structures return the same sequence of output values. Only their latencies differ.

Top module: `fir_pipe_top`

## Requirements
- R1: In the direct structure, each accepted sample x(n) yields out_data = sum over k of COEFS[k]·x(n−k), where COEFS[k] is the signed field at bits [k·CW +: CW], and samples from before the last reset count as zero.
- R2: The transposed structure produces the same output value sequence as the direct structure for the same coefficients and accepted samples.
- R3: out_valid rises exactly L cycles after each cycle with in_valid high and at no other time. With M = 2 when FINE is set and 1 otherwise, L = 1 + M + ceil(log2 NTAPS) for the direct structure and L = 2 + M for the transposed structure.
- R4: The sample history advances only on cycles with in_valid high. in_data on other cycles has no effect, and idle gaps between samples do not change any output value.
- R5: A synchronous active-high rst clears all history and pipeline state. In the cycle after a reset edge, out_valid and out_data are 0.
- R6: With FINE set, each product is formed from two registered partial products, one for the low half of the coefficient and one for the high half. The results equal the unsplit product and the latency is one cycle longer.
- R7: A 4-tap filter is supported in both structures with the same rules.
- R8: Outputs are exact for extreme inputs (−32768, 32767) and extreme coefficients. out_data is DW+CW+ceil(log2 NTAPS) bits wide and never wraps.
- R9: With in_valid high every cycle, a new valid output appears every cycle once the pipeline has filled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks in_data as a new sample |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Marks out_data as a filtered sample |
| out_data | output | DW+CW+ceil(log2 NTAPS) | Signed full-precision filter output |

## Verification
The bench builds six copies with 16-bit data and coefficients: the 3-tap filter in both structures with and without the split multiplier, and the 4-tap filter in the direct structure with the split multiplier and in the transposed structure without it. All six receive the same stimulus, so structural equivalence, the four latency values and the split-product arithmetic are compared cycle by cycle against one arithmetic model. The coefficient sets include −32768, −1 and 32767, and the inputs include the extreme values, which exercises the full output width. The stimulus includes impulses, back-to-back random samples, random valid gaps with junk data on idle cycles, and a reset in the middle of the run.

// File: rtl/fir_pkg.sv
package fir_pkg;

    typedef enum logic {
        FORM_DIRECT     = 1'b0,
        FORM_TRANSPOSED = 1'b1
    } fir_form_e;

    function automatic int mul_stages(bit fine);
        return fine ? 2 : 1;
    endfunction

    function automatic int fir_latency(fir_form_e form, int ntaps, bit fine);
        if (form == FORM_DIRECT)
            return 1 + mul_stages(fine) + $clog2(ntaps);
        return 2 + mul_stages(fine);
    endfunction

endpackage

// File: rtl/fir_mul.sv
module fir_mul #(
    parameter int                     DW   = 16,
    parameter int                     CW   = 16,
    parameter logic signed [CW-1:0]   COEF = '0,
    parameter bit                     FINE = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_v,
    input  logic signed [DW-1:0]      x,
    output logic                      out_v,
    output logic signed [DW+CW-1:0]   p
);
    localparam int PW = DW + CW;
    localparam int LW = CW / 2;
    localparam logic signed [PW-1:0] C_FULL = PW'(COEF);
    localparam logic signed [PW-1:0] C_LO   = PW'({1'b0, COEF[LW-1:0]});
    localparam logic signed [PW-1:0] C_HI   = PW'($signed(COEF[CW-1:LW]));

    typedef struct packed {
        logic          v1;
        logic [PW-1:0] lo;
        logic [PW-1:0] hi;
        logic          v2;
        logic [PW-1:0] p;
    } split_t;

    typedef struct packed {
        logic          v;
        logic [PW-1:0] p;
    } whole_t;

    logic signed [PW-1:0] x_ext;
    assign x_ext = PW'(x);

    generate
        if (FINE) begin : g_split
            split_t st_d, st_q;

            always_comb begin
                st_d    = st_q;
                st_d.v1 = in_v;
                st_d.lo = x_ext * C_LO;
                st_d.hi = x_ext * C_HI;
                st_d.v2 = st_q.v1;
                st_d.p  = ($signed(st_q.hi) <<< LW) + $signed(st_q.lo);
            end

            always_ff @(posedge clk) begin
                if (rst) st_q <= '0;
                else     st_q <= st_d;
            end

            assign out_v = st_q.v2;
            assign p     = $signed(st_q.p);

            AST_SPLIT_EXACT: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && !$past(rst, 2) && $past(in_v, 2))
                    |-> (p == $past(x_ext, 2) * C_FULL)); // R6
        end else begin : g_whole
            whole_t st_d, st_q;

            always_comb begin
                st_d.v = in_v;
                st_d.p = x_ext * C_FULL;
            end

            always_ff @(posedge clk) begin
                if (rst) st_q <= '0;
                else     st_q <= st_d;
            end

            assign out_v = st_q.v;
            assign p     = $signed(st_q.p);
        end
    endgenerate

endmodule

// File: rtl/fir_direct.sv
module fir_direct #(
    parameter int                 NTAPS = 3,
    parameter int                 DW    = 16,
    parameter int                 CW    = 16,
    parameter logic [NTAPS*CW-1:0] COEFS = '0,
    parameter bit                 FINE  = 1'b1
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  in_v,
    input  logic signed [DW-1:0]                  x,
    output logic                                  out_v,
    output logic [DW+CW+$clog2(NTAPS)-1:0]        y
);
    localparam int PW = DW + CW;
    localparam int LV = $clog2(NTAPS);
    localparam int NP = 1 << LV;
    localparam int OW = PW + LV;

    typedef struct packed {
        logic                     v;
        logic [NTAPS-1:0][DW-1:0] h;
    } hist_t;

    typedef struct packed {
        logic [LV-1:0]                 v;
        logic [LV-1:0][NP-1:0][OW-1:0] s;
    } tree_t;

    hist_t hist_d, hist_q;
    tree_t tree_d, tree_q;

    // sample delay line, moves only on accepted samples
    always_comb begin
        hist_d   = hist_q;
        hist_d.v = in_v;
        if (in_v) begin
            hist_d.h[0] = x;
            for (int k = 1; k < NTAPS; k++)
                hist_d.h[k] = hist_q.h[k-1];
        end
    end

    logic signed [PW-1:0] prod [NTAPS];
    logic [NTAPS-1:0]     pv;

    generate
        for (genvar k = 0; k < NTAPS; k++) begin : g_tap
            fir_mul #(
                .DW   (DW),
                .CW   (CW),
                .COEF (COEFS[k*CW +: CW]),
                .FINE (FINE)
            ) u_mul (
                .clk   (clk),
                .rst   (rst),
                .in_v  (hist_q.v),
                .x     ($signed(hist_q.h[k])),
                .out_v (pv[k]),
                .p     (prod[k])
            );
        end
    endgenerate

    logic [NP-1:0][OW-1:0] leaf;

    always_comb begin
        leaf = '0;
        for (int k = 0; k < NTAPS; k++)
            leaf[k] = OW'(prod[k]);
    end

    // balanced adder tree, one register rank per level
    always_comb begin
        tree_d      = '0;
        tree_d.v[0] = &pv;
        for (int l = 1; l < LV; l++)
            tree_d.v[l] = tree_q.v[l-1];
        for (int l = 0; l < LV; l++) begin
            for (int i = 0; i < NP / 2; i++) begin
                if (i < (NP >> (l + 1))) begin
                    if (l == 0)
                        tree_d.s[l][i] = leaf[2*i] + leaf[2*i+1];
                    else
                        tree_d.s[l][i] = tree_q.s[l-1][2*i] + tree_q.s[l-1][2*i+1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            tree_q <= '0;
        end else begin
            hist_q <= hist_d;
            tree_q <= tree_d;
        end
    end

    assign out_v = tree_q.v[LV-1];
    assign y     = tree_q.s[LV-1][0];

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_v |=> $stable(hist_q.h)); // R4

endmodule

// File: rtl/fir_transposed.sv
module fir_transposed #(
    parameter int                 NTAPS = 3,
    parameter int                 DW    = 16,
    parameter int                 CW    = 16,
    parameter logic [NTAPS*CW-1:0] COEFS = '0,
    parameter bit                 FINE  = 1'b1
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  in_v,
    input  logic signed [DW-1:0]                  x,
    output logic                                  out_v,
    output logic [DW+CW+$clog2(NTAPS)-1:0]        y
);
    localparam int PW = DW + CW;
    localparam int OW = PW + $clog2(NTAPS);

    typedef struct packed {
        logic          v;
        logic [DW-1:0] x;
    } inreg_t;

    typedef struct packed {
        logic                     v;
        logic [OW-1:0]            y;
        logic [NTAPS-1:1][OW-1:0] s;
    } chain_t;

    inreg_t in_d, in_q;
    chain_t ch_d, ch_q;

    always_comb begin
        in_d.v = in_v;
        in_d.x = x;
    end

    logic signed [PW-1:0] prod [NTAPS];
    logic [NTAPS-1:0]     pv;
    logic                 pv_all;

    generate
        for (genvar k = 0; k < NTAPS; k++) begin : g_tap
            fir_mul #(
                .DW   (DW),
                .CW   (CW),
                .COEF (COEFS[k*CW +: CW]),
                .FINE (FINE)
            ) u_mul (
                .clk   (clk),
                .rst   (rst),
                .in_v  (in_q.v),
                .x     ($signed(in_q.x)),
                .out_v (pv[k]),
                .p     (prod[k])
            );
        end
    endgenerate

    assign pv_all = &pv;

    // partial-sum chain, moves only when a valid product set arrives
    always_comb begin
        ch_d   = ch_q;
        ch_d.v = pv_all;
        if (pv_all) begin
            ch_d.s[NTAPS-1] = OW'(prod[NTAPS-1]);
            for (int k = 1; k < NTAPS - 1; k++)
                ch_d.s[k] = OW'(prod[k]) + ch_q.s[k+1];
            ch_d.y = OW'(prod[0]) + ch_q.s[1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q <= '0;
            ch_q <= '0;
        end else begin
            in_q <= in_d;
            ch_q <= ch_d;
        end
    end

    assign out_v = ch_q.v;
    assign y     = ch_q.y;

    AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pv_all |=> $stable(ch_q.s)); // R4

endmodule

// File: rtl/fir_pipe_top.sv
module fir_pipe_top #(
    parameter int                  NTAPS = 3,
    parameter int                  DW    = 16,
    parameter int                  CW    = 16,
    parameter logic [NTAPS*CW-1:0] COEFS = {16'h7FFF, 16'hB1E0, 16'h3039},
    parameter fir_pkg::fir_form_e  FORM  = fir_pkg::FORM_TRANSPOSED,
    parameter bit                  FINE  = 1'b1
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   in_valid,
    input  logic signed [DW-1:0]                   in_data,
    output logic                                   out_valid,
    output logic signed [DW+CW+$clog2(NTAPS)-1:0]  out_data
);
    localparam int OW  = DW + CW + $clog2(NTAPS);
    localparam int LAT = fir_pkg::fir_latency(FORM, NTAPS, FINE);

    logic [OW-1:0] y_raw;

    generate
        if (FORM == fir_pkg::FORM_DIRECT) begin : g_direct
            fir_direct #(
                .NTAPS (NTAPS), .DW (DW), .CW (CW), .COEFS (COEFS), .FINE (FINE)
            ) u_core (
                .clk   (clk),
                .rst   (rst),
                .in_v  (in_valid),
                .x     (in_data),
                .out_v (out_valid),
                .y     (y_raw)
            );
        end else begin : g_transposed
            fir_transposed #(
                .NTAPS (NTAPS), .DW (DW), .CW (CW), .COEFS (COEFS), .FINE (FINE)
            ) u_core (
                .clk   (clk),
                .rst   (rst),
                .in_v  (in_valid),
                .x     (in_data),
                .out_v (out_valid),
                .y     (y_raw)
            );
        end
    endgenerate

    assign out_data = $signed(y_raw);

    // cycles since reset, used only to bound the latency check window
    logic [7:0] age_d, age_q;

    always_comb begin
        age_d = age_q;
        if (age_q < 8'(LAT))
            age_d = age_q + 8'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) age_q <= '0;
        else     age_q <= age_d;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_data == '0)); // R5

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (age_q == 8'(LAT)) |-> (out_valid == $past(in_valid, LAT))); // R3

endmodule

// File: tb/test_fir_pipe_top.sv
`timescale 1ns/1ps
module test_fir_pipe_top;
    import fir_pkg::*;

    localparam int NDUT = 6;
    localparam int MAXC = 8192;
    localparam logic [47:0] K3 = {16'h7FFF, 16'hB1E0, 16'h3039};
    localparam logic [63:0] K4 = {16'h0007, 16'hFFFF, 16'h03E8, 16'h8000};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [15:0] in_data = '0;
    logic              ov [NDUT];
    logic signed [33:0] od [NDUT];

    always #2 clk = ~clk;

    fir_pipe_top #(.NTAPS(3), .COEFS(K3), .FORM(FORM_DIRECT), .FINE(1'b0)) i_fir_pipe_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .out_valid(ov[0]), .out_data(od[0]));
    fir_pipe_top #(.NTAPS(3), .COEFS(K3), .FORM(FORM_DIRECT), .FINE(1'b1)) i_fir_pipe_top_d3f (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .out_valid(ov[1]), .out_data(od[1]));
    fir_pipe_top #(.NTAPS(3), .COEFS(K3), .FORM(FORM_TRANSPOSED), .FINE(1'b0)) i_fir_pipe_top_t3c (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .out_valid(ov[2]), .out_data(od[2]));
    fir_pipe_top #(.NTAPS(3), .COEFS(K3), .FORM(FORM_TRANSPOSED), .FINE(1'b1)) i_fir_pipe_top_t3f (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .out_valid(ov[3]), .out_data(od[3]));
    fir_pipe_top #(.NTAPS(4), .COEFS(K4), .FORM(FORM_DIRECT), .FINE(1'b1)) i_fir_pipe_top_d4f (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .out_valid(ov[4]), .out_data(od[4]));
    fir_pipe_top #(.NTAPS(4), .COEFS(K4), .FORM(FORM_TRANSPOSED), .FINE(1'b0)) i_fir_pipe_top_t4c (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .out_valid(ov[5]), .out_data(od[5]));

    // latency per R3: direct 1+M+2, transposed 2+M
    int    lat  [NDUT] = '{4, 5, 3, 4, 5, 3};
    bit    four [NDUT] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
    string tag  [NDUT] = '{"R1", "R6", "R2", "R6", "R7", "R7"};
    string nm   [NDUT] = '{"d3c", "d3f", "t3c", "t3f", "d4f", "t4c"};
    longint c3 [3] = '{12345, -20000, 32767};
    longint c4 [4] = '{-32768, 1000, -1, 7};

    bit     vlog [MAXC];
    bit     rlog [MAXC];
    longint e3 [MAXC];
    longint e4 [MAXC];
    longint hist [4];
    int     cyc = 0;
    int     n_chk = 0;
    int     n_fail = 0;
    string  phase = "R5";

    task automatic check(bit ok, string req, string what, longint got, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", req, what, got, exp, cyc);
        end
    endtask

    task automatic check_outputs();
        for (int j = 0; j < NDUT; j++) begin
            if (cyc > 0 && rlog[cyc-1]) begin
                check(ov[j] === 1'b0 && od[j] === '0, "R5", {nm[j], " cleared by reset"},
                      longint'(od[j]), 0);
            end else begin
                bit ev;
                ev = (cyc >= lat[j]) ? vlog[cyc-lat[j]] : 1'b0;
                check(ov[j] === ev, "R3", {nm[j], " out_valid timing"}, longint'(ov[j]), longint'(ev));
                if (ev) begin
                    longint ex;
                    ex = four[j] ? e4[cyc-lat[j]] : e3[cyc-lat[j]];
                    check(longint'(od[j]) == ex && !$isunknown(od[j]),
                          {phase, "/", tag[j]}, {nm[j], " out_data"}, longint'(od[j]), ex);
                end
            end
        end
    endtask

    task automatic step(bit r, bit v, logic signed [15:0] d);
        @(negedge clk);
        rlog[cyc] = r;
        if (!r) check_outputs();
        rst      = r;
        in_valid = v;
        in_data  = d;
        vlog[cyc] = v && !r;
        if (r) begin
            for (int k = 0; k < 4; k++) hist[k] = 0;
        end else if (v) begin
            longint s3, s4;
            for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = longint'(d);
            s3 = 0;
            s4 = 0;
            for (int k = 0; k < 3; k++) s3 += c3[k] * hist[k];
            for (int k = 0; k < 4; k++) s4 += c4[k] * hist[k];
            e3[cyc] = s3;
            e4[cyc] = s4;
        end
        cyc++;
    endtask

    function automatic logic signed [15:0] extreme();
        case ($urandom % 4)
            0: return 16'sh8000;
            1: return 16'sh7FFF;
            2: return -16'sd1;
            default: return 16'sd0;
        endcase
    endfunction

    initial begin
        #(4 * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL R9 watchdog expired at cycle %0d", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) hist[k] = 0;
        // R5: initial reset then idle
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, '0);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, '0);
        // R1: impulses of both signs expose each tap weight
        phase = "R1";
        step(1'b0, 1'b1, 16'sd1);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, '0);
        step(1'b0, 1'b1, -16'sd1);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, '0);
        // R9: back-to-back random samples
        phase = "R9";
        for (int i = 0; i < 300; i++) step(1'b0, 1'b1, 16'($urandom));
        // R4: random gaps, junk data on idle cycles
        phase = "R4";
        for (int i = 0; i < 400; i++) step(1'b0, ($urandom % 3) != 0, 16'($urandom));
        // R8: extreme sample values
        phase = "R8";
        for (int i = 0; i < 200; i++) step(1'b0, ($urandom % 4) != 0, extreme());
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 16'sh8000);
        // R5: drain, reset mid-run, history must restart from zero
        phase = "R5";
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 16'($urandom));
        step(1'b1, 1'b1, 16'sh7FFF);
        step(1'b1, 1'b0, '0);
        for (int i = 0; i < 100; i++) step(1'b0, ($urandom % 2) != 0, 16'($urandom));
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0, '0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule